// File: doc/BRIEF.md
# Ancillary Word FIFO with Sticky Overrun

This block holds ancillary data words on their way into a video stream. A producer pushes words over a valid/ready write channel and a consumer pulls them in arrival order over a valid/ready read channel. Three status flags report the buffer's state: empty, full and overrun. Any one of them can be steered onto a single general-purpose output pin.

Overrun is sticky. It latches when a write is attempted while the buffer is full, and it stays latched until the host strobes a status read. The flag holds through the read cycle, so the host sees it, and it drops on the next cycle.

Either of two dynamic flush controls changes what an overflow does. With flush on, the overrun function is switched off. A write into a full buffer then throws away everything stored and keeps only the new word.

Write-side back-pressure rules:
- While `in_ready` is low, a word offered with `in_valid` is not accepted.
- That refused offer counts as an overrun attempt.

Read-side rules:
- The consumer takes a word on any edge where `out_valid` and `out_ready` are both high.
- `out_data` may be sampled whenever `out_valid` is high.

Top module: `anc_fifo_top`

## Requirements
- R1: After reset the block shows `flag_empty`=1, `flag_full`=0, `flag_overrun`=0, `out_valid`=0 and `out_data`=0.
- R2: Words leave in the order they were accepted. `flag_empty` and `flag_full` reflect the number of stored words one edge after each handshake. `flag_full` is set at DEPTH (default 16) words.
- R3: With both flush controls off and the buffer full, `in_ready` is 0. A word offered then is dropped, and the stored words are unchanged.
- R4: With both flush controls off, an offer while full sets `flag_overrun` at the next edge.
- R5: `flag_overrun` stays set until a cycle with `stat_rd`=1. It reads 1 during that cycle and 0 after the following edge.
- R6: If a status read and a new overrun attempt fall in the same cycle, `flag_overrun` stays set.
- R7: While `flush_fifo_dyn` or `flush_msg_dyn` is 1, `in_ready` is 1 and `flag_overrun` is 0 from the next edge on.
- R8: With flush on, an offer while full discards all stored words in one edge. After that edge the buffer holds only the new word.
- R9: A read attempt while empty changes nothing. `out_valid` stays 0 and `out_data` keeps the last word that was taken (0 if none).
- R10: `gp_pin` shows one flag, picked by `pin_sel`: 0 picks empty, 1 picks full, 2 picks overrun, and 3 drives a constant 0.
- R11: A write and a read in the same cycle, on a buffer that is neither empty nor full, leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer accepts the offered word |
| in_data | input | DW | Offered word |
| out_valid | output | 1 | A word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW | Head word, or last word taken when empty |
| stat_rd | input | 1 | Host status read strobe; clears overrun |
| flush_fifo_dyn | input | 1 | Dynamic flush control A |
| flush_msg_dyn | input | 1 | Dynamic flush control B |
| pin_sel | input | 2 | Flag routed to gp_pin |
| flag_empty | output | 1 | No words stored |
| flag_full | output | 1 | DEPTH words stored |
| flag_overrun | output | 1 | Sticky overrun status |
| gp_pin | output | 1 | Selected flag |

## Verification
Every output is decoded without further delay from registered state. A handshake or an overflow offer therefore shows in `flag_empty`, `flag_full`, `out_valid`, `out_data` and `in_ready` exactly one edge later. `flag_overrun` also moves one edge after the attempt, and it drops one edge after the read strobe. The bench drives inputs at the falling edge, samples every output 1 ns later, and then advances a behavioural queue model by one edge. Each comparison is therefore against the state the requirements predict for that exact cycle.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;
  typedef enum logic [1:0] {
    PIN_EMPTY   = 2'd0,
    PIN_FULL    = 2'd1,
    PIN_OVERRUN = 2'd2,
    PIN_LOW     = 2'd3
  } pin_sel_e;
endpackage

// File: rtl/anc_fifo_store.sv
module anc_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          flush_wr,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [DW-1:0] last,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // pointer advance: free wrap for power-of-two depths, compare otherwise
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en || flush_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last   <= '0;
    end else begin
      if (rd_en) last <= mem[rd_ptr];
      if (flush_wr) begin
        rd_ptr <= wr_ptr;
        wr_ptr <= wr_nxt;
        count  <= CW'(1);
      end else begin
        if (wr_en) wr_ptr <= wr_nxt;
        if (rd_en) rd_ptr <= rd_nxt;
        count <= count + CW'(wr_en) - CW'(rd_en);
      end
    end
  end
endmodule

// File: rtl/anc_fifo_ovr.sv
module anc_fifo_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic attempt,
  input  logic flush_on,
  input  logic host_rd,
  output logic ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n)        ovr <= 1'b0;
    else if (flush_on) ovr <= 1'b0;
    else if (attempt)  ovr <= 1'b1;
    else if (host_rd)  ovr <= 1'b0;
  end
endmodule

// File: rtl/anc_fifo_pinmux.sv
module anc_fifo_pinmux
  import anc_fifo_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       st_empty,
  input  logic       st_full,
  input  logic       st_ovr,
  output logic       pin
);
  always_comb begin
    case (pin_sel_e'(sel))
      PIN_EMPTY:   pin = st_empty;
      PIN_FULL:    pin = st_full;
      PIN_OVERRUN: pin = st_ovr;
      default:     pin = 1'b0;
    endcase
  end
endmodule

// File: rtl/anc_fifo_top.sv
module anc_fifo_top #(
  parameter int DEPTH = 16,
  parameter int DW    = 10,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          stat_rd,
  input  logic          flush_fifo_dyn,
  input  logic          flush_msg_dyn,
  input  logic [1:0]    pin_sel,
  output logic          flag_empty,
  output logic          flag_full,
  output logic          flag_overrun,
  output logic          gp_pin
);
  logic [CW-1:0] count;
  logic [DW-1:0] head, last;
  logic flush_on, full_hit, wr_en, flush_wr, rd_en;

  assign flag_empty = (count == '0);
  assign flag_full  = (count == CW'(DEPTH));
  assign flush_on   = flush_fifo_dyn | flush_msg_dyn;
  assign full_hit   = in_valid & flag_full;
  assign wr_en      = in_valid & ~flag_full;
  assign flush_wr   = full_hit & flush_on;
  assign rd_en      = out_ready & ~flag_empty;

  assign in_ready  = ~flag_full | flush_on;
  assign out_valid = ~flag_empty;
  assign out_data  = flag_empty ? last : head;

  anc_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flush_wr(flush_wr),
    .rd_en(rd_en), .wdata(in_data), .head(head), .last(last), .count(count)
  );

  anc_fifo_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .attempt(full_hit), .flush_on(flush_on),
    .host_rd(stat_rd), .ovr(flag_overrun)
  );

  anc_fifo_pinmux u_pin (
    .sel(pin_sel), .st_empty(flag_empty), .st_full(flag_full),
    .st_ovr(flag_overrun), .pin(gp_pin)
  );
endmodule

// File: rtl/anc_fifo_chk.sv
module anc_fifo_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          stat_rd,
  input logic          flush_fifo_dyn,
  input logic          flush_msg_dyn,
  input logic          flag_empty,
  input logic          flag_full,
  input logic          flag_overrun
);
  // R2
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_empty && flag_full));
  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flag_full && !flush_fifo_dyn && !flush_msg_dyn) |=> flag_overrun);
  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overrun && !stat_rd && !flush_fifo_dyn && !flush_msg_dyn) |=> flag_overrun);
  // R5
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(in_valid && flag_full)) |=> !flag_overrun);
  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_fifo_dyn || flush_msg_dyn) |=> !flag_overrun);
  // R7
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_fifo_dyn || flush_msg_dyn) |-> in_ready);
  // R8
  flush_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flag_full && (flush_fifo_dyn || flush_msg_dyn)) |=> (!flag_empty && !flag_full));
  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> (!out_valid && $stable(out_data)));
endmodule

bind anc_fifo_top anc_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .stat_rd(stat_rd),
  .flush_fifo_dyn(flush_fifo_dyn), .flush_msg_dyn(flush_msg_dyn),
  .flag_empty(flag_empty), .flag_full(flag_full), .flag_overrun(flag_overrun)
);

// File: tb/anc_fifo_top_tb_top.sv
module anc_fifo_top_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, stat_rd = 1'b0;
  logic flush_fifo_dyn = 1'b0, flush_msg_dyn = 1'b0;
  logic [1:0] pin_sel = 2'd0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, flag_empty, flag_full, flag_overrun, gp_pin;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  anc_fifo_top #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .stat_rd(stat_rd), .flush_fifo_dyn(flush_fifo_dyn),
    .flush_msg_dyn(flush_msg_dyn), .pin_sel(pin_sel), .flag_empty(flag_empty),
    .flag_full(flag_full), .flag_overrun(flag_overrun), .gp_pin(gp_pin)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [DW-1:0] q [$];
  logic [DW-1:0] m_last = '0;
  logic m_ovr = 1'b0;

  task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    bit m_empty, m_full, m_gp;
    m_empty = (q.size() == 0);
    m_full  = (q.size() == DEPTH);
    case (pin_sel)
      2'd0: m_gp = m_empty;
      2'd1: m_gp = m_full;
      2'd2: m_gp = m_ovr;
      default: m_gp = 1'b0;
    endcase
    check("flag_empty", 16'(flag_empty), 16'(m_empty));
    check("flag_full", 16'(flag_full), 16'(m_full));
    check("out_valid", 16'(out_valid), 16'(!m_empty));
    check("out_data", 16'(out_data), 16'(m_empty ? m_last : q[0]));
    check("in_ready", 16'(in_ready), 16'(!m_full || flush_fifo_dyn || flush_msg_dyn));
    check("flag_overrun", 16'(flag_overrun), 16'(m_ovr));
    check("gp_pin R10", 16'(gp_pin), 16'(m_gp));
  endtask

  task automatic model_edge();
    bit fl, full0;
    fl = flush_fifo_dyn || flush_msg_dyn;
    full0 = (q.size() == DEPTH);
    if (out_ready && q.size() != 0) begin
      m_last = q[0];
      void'(q.pop_front());
    end
    if (in_valid) begin
      if (!full0) q.push_back(in_data);
      else if (fl) begin
        q.delete();
        q.push_back(in_data);
      end
    end
    if (fl) m_ovr = 1'b0;
    else if (in_valid && full0) m_ovr = 1'b1;
    else if (stat_rd) m_ovr = 1'b0;
  endtask

  task automatic cyc(input bit iv, input logic [DW-1:0] d, input bit ordy,
                     input bit srd, input bit fa, input bit fb, input logic [1:0] sel);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; stat_rd = srd;
    flush_fifo_dyn = fa; flush_msg_dyn = fb; pin_sel = sel;
    #1;
    compare_all();
    model_edge();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    cur_req = "R1";
    check("empty", 16'(flag_empty), 16'd1);
    check("full", 16'(flag_full), 16'd0);
    check("overrun", 16'(flag_overrun), 16'd0);
    check("out_valid", 16'(out_valid), 16'd0);
    check("out_data", 16'(out_data), 16'd0);
    rst_n = 1'b1;

    // R9: read attempt while empty after reset
    cur_req = "R9";
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0, 0, 0, 2'd0);

    // R2: fill to DEPTH
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) cyc(1, DW'(10'h100 + i), 0, 0, 0, 0, 2'd1);

    // R3 / R4: offers while full are dropped and set overrun
    cur_req = "R3";
    cyc(1, 10'h3AA, 0, 0, 0, 0, 2'd1);
    cur_req = "R4";
    cyc(1, 10'h3BB, 0, 0, 0, 0, 2'd2);

    // R5: sticky, then cleared by a status read
    cur_req = "R5";
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 0, 0, 0, 2'd2);
    cyc(0, '0, 0, 1, 0, 0, 2'd2);
    cyc(0, '0, 0, 0, 0, 0, 2'd2);

    // R6: read and new overrun in the same cycle
    cur_req = "R6";
    cyc(1, 10'h3CC, 0, 0, 0, 0, 2'd2);
    cyc(1, 10'h3DD, 0, 1, 0, 0, 2'd2);
    cyc(0, '0, 0, 0, 0, 0, 2'd2);
    cyc(0, '0, 0, 1, 0, 0, 2'd2);

    // R2 / R3: drain; stored words must be the original ones
    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) cyc(0, '0, 1, 0, 0, 0, 2'd0);

    // R9: reads while empty keep last word
    cur_req = "R9";
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0, 0, 0, 2'd0);

    // R11: simultaneous push and pop
    cur_req = "R11";
    for (int i = 0; i < 4; i++) cyc(1, DW'(10'h050 + i), 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 6; i++) cyc(1, DW'(10'h060 + i), 1, 0, 0, 0, 2'd0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, 0, 0, 2'd0);

    // R7 / R8: flush on overflow, each control
    cur_req = "R8";
    for (int i = 0; i < DEPTH; i++) cyc(1, DW'(10'h200 + i), 0, 0, 0, 0, 2'd1);
    cyc(1, 10'h3EE, 0, 0, 0, 0, 2'd2);
    cur_req = "R7";
    cyc(0, '0, 0, 0, 1, 0, 2'd2);
    cur_req = "R8";
    cyc(1, 10'h2F0, 0, 0, 1, 0, 2'd2);
    cyc(0, '0, 1, 0, 1, 0, 2'd0);
    for (int i = 0; i < DEPTH; i++) cyc(1, DW'(10'h280 + i), 0, 0, 0, 1, 2'd1);
    cyc(1, 10'h2F1, 1, 0, 0, 1, 2'd1);
    cyc(1, 10'h2F2, 0, 0, 0, 1, 2'd1);
    cyc(0, '0, 1, 0, 0, 0, 2'd0);
    cyc(0, '0, 1, 0, 0, 0, 2'd0);

    // R10: constant-low selection
    cur_req = "R10";
    cyc(0, '0, 0, 0, 0, 0, 2'd3);

    // R2: random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      cyc(bit'($urandom % 3 != 0), DW'($urandom), bit'($urandom % 2),
          bit'($urandom % 8 == 0), bit'($urandom % 20 == 0),
          bit'($urandom % 25 == 0), 2'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule